// File: doc/BRIEF.md
# Signed Multiply-Accumulate Register Peripheral

This peripheral multiplies two 16-bit two's complement operands and adds the 32-bit product into a 32-bit accumulator. Software reaches it through a plain single-cycle register port: one write strobe, a 3-bit word address, 16-bit write data and a combinational read-data path. The operation runs only while the mode register holds 8'h48. Writing the multiplier starts it. The product appears one clock after that write. The sum lands in the accumulator one clock later.

Software can preload the accumulator in two halves, in either order. The multiplicand register keeps its value between operations, so a chain of products needs only a new multiplier write each time. The accumulator wraps and does not saturate. A sign flag tracks the sign of the accumulator. A sticky overflow flag and a one-cycle interrupt pulse report a signed 32-bit overflow.

Register map by address: 0 mode, 1 accumulator low half, 2 accumulator high half, 3 multiplicand, 4 multiplier, 5 product low half (read only), 6 product high half (read only), 7 status.

Top module: `smac_unit`

## Requirements
- R1: After reset every address reads 0 and `irq` is low.
- R2: An operation starts only when a multiplier write (address 4) arrives while the mode register (address 0, low 8 bits) holds 8'h48. With any other mode value, a multiplier write stores the operand, leaves busy low and leaves the accumulator unchanged.
- R3: The accumulator low half (address 1) and high half (address 2) can be written in either order, and each reads back the value written.
- R4: One clock after the starting write, address 5 reads bits 15:0 and address 6 reads bits 31:16 of the signed product of the multiplicand (address 3) and the multiplier (address 4).
- R5: Two clocks after the starting write, the accumulator holds its previous value plus the product, wrapped modulo 2^32.
- R6: Status bit 0 (sign) takes bit 15 of every accepted high-half preload. After each accumulate it equals bit 31 of the result.
- R7: When an accumulate leaves the signed 32-bit range, status bit 1 (overflow) is set and `irq` is high for exactly that one cycle, together with the updated result.
- R8: The overflow flag is sticky. Later operations that do not overflow leave it at 1, and so does a status write with bit 1 set. A status write with bit 1 clear, or any write to the mode register, clears it.
- R9: Successive multiplier writes reuse the stored multiplicand and keep accumulating onto the current accumulator value.
- R10: Status bit 2 (busy) is 1 for exactly the two cycles after a starting write. A multiplier write while busy is ignored, and address 4 keeps reading the earlier value.
- R11: Writes to either accumulator half while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | One-cycle pulse when an accumulate overflows |

## Verification
The hardest situation to reach is a write that lands inside the two-cycle pipeline window: a second multiplier write, or an accumulator preload, one or two clocks after the start. The bench issues register writes on consecutive clocks with no idle gap, so these writes fall exactly on the multiply cycle and the accumulate cycle. It then reads the multiplier and the accumulator back to show the writes had no effect. Overflow is reached by sweeping operand corner values against accumulator preloads at both extremes of the signed range.

// File: rtl/smac_unit.sv
`timescale 1ns/1ps
module smac_unit #(
  parameter int W = 16,
  parameter int AW = 3,
  parameter logic [7:0] MODE_MAC = 8'h48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          irq
);
  localparam int PW = 2 * W;
  localparam logic [AW-1:0] A_MODE = AW'(0), A_ACCL = AW'(1), A_ACCH = AW'(2), A_MCND = AW'(3),
                            A_MPLR = AW'(4), A_PRDL = AW'(5), A_PRDH = AW'(6), A_STAT = AW'(7);

  logic [7:0]    mode_q;
  logic [W-1:0]  mcnd_q, mplr_q;
  logic [PW-1:0] prod_q, acc_q;
  logic          mul_v, acc_v, sign_q, ovf_q;
  logic          busy;

  assign busy = mul_v | acc_v;

  wire wr_mplr  = wr_en && addr == A_MPLR && !busy;
  wire start_op = wr_mplr && mode_q == MODE_MAC;
  wire wr_accl  = wr_en && addr == A_ACCL && !busy;
  wire wr_acch  = wr_en && addr == A_ACCH && !busy;

  wire [PW-1:0] prod_c = PW'($signed(mcnd_q)) * PW'($signed(mplr_q));
  wire [PW-1:0] sum    = acc_q + prod_q;
  wire ovf_now = (acc_q[PW-1] == prod_q[PW-1]) && (sum[PW-1] != acc_q[PW-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mcnd_q <= '0;
      mplr_q <= '0;
      prod_q <= '0;
      acc_q  <= '0;
      mul_v  <= 1'b0;
      acc_v  <= 1'b0;
      sign_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq   <= 1'b0;
      mul_v <= start_op;
      acc_v <= mul_v;
      if (wr_en && addr == A_MODE) begin
        mode_q <= wdata[7:0];
        ovf_q  <= 1'b0;
      end
      if (wr_en && addr == A_STAT && !wdata[1]) ovf_q <= 1'b0;
      if (wr_en && addr == A_MCND) mcnd_q <= wdata;
      if (wr_mplr) mplr_q <= wdata;
      if (mul_v) prod_q <= prod_c;
      if (wr_accl) acc_q[W-1:0] <= wdata;
      if (wr_acch) begin
        acc_q[PW-1:W] <= wdata;
        sign_q        <= wdata[W-1];
      end
      if (acc_v) begin
        acc_q  <= sum;
        sign_q <= sum[PW-1];
        if (ovf_now) begin
          ovf_q <= 1'b1;
          irq   <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_MODE:  rdata = {{(W-8){1'b0}}, mode_q};
      A_ACCL:  rdata = acc_q[W-1:0];
      A_ACCH:  rdata = acc_q[PW-1:W];
      A_MCND:  rdata = mcnd_q;
      A_MPLR:  rdata = mplr_q;
      A_PRDL:  rdata = prod_q[W-1:0];
      A_PRDH:  rdata = prod_q[PW-1:W];
      A_STAT:  rdata = {{(W-3){1'b0}}, busy, ovf_q, sign_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/smac_unit_chk.sv
`timescale 1ns/1ps
module smac_unit_chk #(
  parameter int W = 16,
  parameter int AW = 3,
  parameter logic [7:0] MODE_MAC = 8'h48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic          irq,
  input logic          busy,
  input logic          acc_v,
  input logic          ovf_q,
  input logic [7:0]    mode_q,
  input logic [W-1:0]  mplr_q,
  input logic [2*W-1:0] acc_q
);
  localparam logic [AW-1:0] C_MODE = AW'(0), C_ACCL = AW'(1), C_ACCH = AW'(2),
                            C_MPLR = AW'(4), C_STAT = AW'(7);

  wire clr_ovf = wr_en && (addr == C_MODE || (addr == C_STAT && !wdata[1]));
  wire acc_wr  = wr_en && (addr == C_ACCL || addr == C_ACCH) && !busy;

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R7
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ovf_q); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_q && !clr_ovf) |=> ovf_q); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_MPLR && mode_q == MODE_MAC && !busy) |=> busy); // R10
  AST_BUSY_HOLDS_MPLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_MPLR && busy) |=> $stable(mplr_q)); // R10
  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_v && !acc_wr) |=> $stable(acc_q)); // R11
endmodule

bind smac_unit smac_unit_chk #(.W(W), .AW(AW), .MODE_MAC(MODE_MAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq),
  .busy(busy), .acc_v(acc_v), .ovf_q(ovf_q), .mode_q(mode_q), .mplr_q(mplr_q), .acc_q(acc_q)
);

// File: tb/test_smac_unit.sv
`timescale 1ns/1ps
module test_smac_unit;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  smac_unit i_smac_unit (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                         .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #0.1; d = rdata;
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(3'd1, lo); rd(3'd2, hi); v = {hi, lo};
  endtask

  task automatic rdprod(output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(3'd5, lo); rd(3'd6, hi); v = {hi, lo};
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  logic [15:0] vals [10] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002, 16'hFFFD,
                             16'h7FFF, 16'h8000, 16'h1234, 16'hEDCB, 16'h0100};
  logic [31:0] accs [4] = '{32'h0000_0000, 32'h7FFF_FFF0, 32'h8000_0010, 32'hFFFF_FFFF};

  initial begin
    logic [15:0] d;
    logic [31:0] v, accx;
    longint p, s;
    bit ov;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reset addr %0d", a), {16'h0, d}, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irq}, 32'h0);

    wr(3'd0, 16'h0048);
    rd(3'd0, d); chk("R2 mode readback", {16'h0, d}, 32'h48);

    for (int ia = 0; ia < 10; ia++)
      for (int ib = 0; ib < 10; ib++)
        for (int ic = 0; ic < 4; ic++) begin
          wr(3'd7, 16'h0000);
          if ((ia + ib + ic) % 2 == 0) begin
            wr(3'd2, accs[ic][31:16]); wr(3'd1, accs[ic][15:0]);
          end else begin
            wr(3'd1, accs[ic][15:0]); wr(3'd2, accs[ic][31:16]);
          end
          rd32(v); chk("R3 preload", v, accs[ic]);
          rd(3'd7, d); chk("R6 sign after preload", {31'h0, d[0]}, {31'h0, accs[ic][31]});
          wr(3'd3, vals[ia]);
          wr(3'd4, vals[ib]);
          p = longint'($signed(vals[ia])) * longint'($signed(vals[ib]));
          s = longint'($signed(accs[ic])) + p;
          ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
          rd(3'd7, d); chk("R10 busy cycle 1", {31'h0, d[2]}, 32'h1);
          @(negedge clk);
          rdprod(v); chk("R4 product", v, p[31:0]);
          rd(3'd7, d); chk("R10 busy cycle 2", {31'h0, d[2]}, 32'h1);
          @(negedge clk);
          rd32(v); chk("R5 accumulate", v, s[31:0]);
          rd(3'd7, d);
          chk("R6 sign after accumulate", {31'h0, d[0]}, {31'h0, s[31]});
          chk("R7 overflow flag", {31'h0, d[1]}, {31'h0, ov});
          chk("R10 busy released", {31'h0, d[2]}, 32'h0);
          chk("R7 irq pulse", {31'h0, irq}, {31'h0, ov});
          @(negedge clk);
          chk("R7 irq one cycle", {31'h0, irq}, 32'h0);
        end

    wr(3'd7, 16'h0000);
    wr(3'd2, 16'h0000); wr(3'd1, 16'h0000); wr(3'd3, 16'd3);
    accx = 32'h0;
    for (int k = 0; k < 3; k++) begin
      logic [15:0] m;
      m = (k == 0) ? 16'd5 : (k == 1) ? 16'hFFF9 : 16'd100;
      wr(3'd4, m);
      @(negedge clk); @(negedge clk);
      accx = accx + 32'(longint'(3) * longint'($signed(m)));
      rd32(v); chk("R9 chained accumulate", v, accx);
    end

    wr(3'd1, 16'h0010); wr(3'd2, 16'h0000); wr(3'd3, 16'd4);
    wr(3'd4, 16'd2);
    wr(3'd4, 16'd9);
    wr(3'd1, 16'hFFFF);
    rd32(v); chk("R10 R11 writes during busy ignored", v, 32'h18);
    rd(3'd4, d); chk("R10 multiplier kept", {16'h0, d}, 32'h2);

    wr(3'd2, 16'h7FFF); wr(3'd1, 16'hFFFF); wr(3'd3, 16'd1); wr(3'd4, 16'd1);
    @(negedge clk); @(negedge clk);
    rd(3'd7, d); chk("R7 overflow at top edge", {31'h0, d[1]}, 32'h1);
    wr(3'd4, 16'd1);
    @(negedge clk); @(negedge clk);
    rd(3'd7, d); chk("R8 sticky after clean op", {31'h0, d[1]}, 32'h1);
    wr(3'd7, 16'h0002);
    rd(3'd7, d); chk("R8 write of one keeps flag", {31'h0, d[1]}, 32'h1);
    wr(3'd7, 16'h0000);
    rd(3'd7, d); chk("R8 status clear", {31'h0, d[1]}, 32'h0);
    wr(3'd2, 16'h7FFF); wr(3'd1, 16'hFFFF); wr(3'd4, 16'd1);
    @(negedge clk); @(negedge clk);
    wr(3'd0, 16'h0000);
    rd(3'd7, d); chk("R8 mode write clears flag", {31'h0, d[1]}, 32'h0);

    rd32(accx);
    wr(3'd4, 16'd5);
    rd(3'd7, d); chk("R2 no busy when mode off", {31'h0, d[2]}, 32'h0);
    @(negedge clk); @(negedge clk);
    rd32(v); chk("R2 accumulator untouched", v, accx);
    rd(3'd4, d); chk("R2 operand stored", {16'h0, d}, 32'h5);

    done = 1;
    finish_run();
  end
endmodule